// File: doc/BRIEF.md
# Receive Descriptor Ring Fetcher

This block looks after one ring of receive descriptors kept in host memory. Software programs the ring's start address and its length in descriptors, then publishes work by writing a tail index. The block reads descriptors from memory in short bursts into a 64-entry on-chip circular queue. It offers them one at a time to the packet receive path. It moves its head index forward only when the write-back of used descriptors to host memory is reported as complete.

Each descriptor is 16 bytes, so a fetch address is the ring start plus sixteen times the ring index. A burst never runs past the last slot of the ring. When the readable region wraps, the fetch is split into one burst up to the ring end and a later burst from index zero. Fetching stops at the tail index. It also stops while the queue, counting the beats already requested but not yet returned, has no room. It resumes without help once entries are consumed.

The read request channel is valid/ready. A request, once raised, keeps its address and length until it is granted. The read data channel has no back-pressure, because queue space is reserved when the request is formed. Data beats must return in request order, one descriptor per beat. The descriptor output is valid/ready: the receive path raises `desc_ready` once per arriving packet. A descriptor is consumed only when `desc_valid` is also high. If the queue is empty at that moment, the block instead raises `no_desc` on the following cycle and consumes nothing.

Top module: `rx_desc_ring_fetcher`

## Requirements
- R1: While reset is asserted and immediately after it, `rd_req_valid`, `desc_valid` and `no_desc` are low, and `head_idx` and `desc_index` are 0.
- R2: Every granted read request carries `rd_req_addr` equal to `cfg_base` + 16 × (ring index of its first descriptor). Successive requests start where the previous one ended, modulo `cfg_size`.
- R3: No descriptor at or beyond the tail index is ever requested. A request's length never exceeds (tail − fetch index) mod `cfg_size`. With tail equal to head, including a tail write of the head value, no request is issued.
- R4: `rd_req_len` is between 1 and BURST_MAX (8 by default). The first index plus the length never exceeds `cfg_size`, so a region that wraps is fetched as a burst ending at the ring end and then a burst starting at index 0.
- R5: Queued descriptors plus requested-but-unreturned beats never exceed 64. With no consumption and enough published descriptors, exactly 64 are fetched. Fetching resumes by the number consumed.
- R6: While `rd_req_valid` is high and `rd_req_ready` is low, the next cycle still has `rd_req_valid` high with unchanged `rd_req_addr` and `rd_req_len`.
- R7: `desc_valid` is high exactly when the queue holds a descriptor. Descriptors leave in the order their data beats arrived, one per cycle in which `desc_valid` and `desc_ready` are both high.
- R8: When `desc_ready` is high while `desc_valid` is low, `no_desc` is high for the next cycle only. No descriptor is consumed, and `desc_index` does not advance.
- R9: `head_idx` changes only in the cycle after `wb_valid`. It advances by the smaller of `wb_count` and the number of consumed descriptors not yet written back, modulo `cfg_size`.
- R10: `desc_index` (the ring index of the offered descriptor) and `head_idx` stay below `cfg_size` and wrap from `cfg_size` − 1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_base | input | ADDR_W | Host byte address of ring index 0, held stable outside reset |
| cfg_size | input | IDX_W | Ring length in descriptors (at least 2), held stable outside reset |
| tail_wr_en | input | 1 | Strobe: load a new tail index |
| tail_wr_idx | input | IDX_W | Tail index written by software |
| head_idx | output | IDX_W | Head index, advanced on write-back completion |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request grant |
| rd_req_addr | output | ADDR_W | Byte address of the first descriptor of the burst |
| rd_req_len | output | LEN_W | Burst length in descriptors |
| rd_data_valid | input | 1 | One descriptor beat returned |
| rd_data | input | DESC_W | Returned descriptor contents |
| desc_valid | output | 1 | A fetched descriptor is on offer |
| desc_ready | input | 1 | Receive path takes a descriptor (one per packet) |
| desc_data | output | DESC_W | Offered descriptor contents |
| desc_index | output | IDX_W | Ring index of the offered descriptor |
| no_desc | output | 1 | One-cycle pulse: a packet found the queue empty |
| wb_valid | input | 1 | Write-back completion strobe |
| wb_count | input | IDX_W | Number of used descriptors written back |

## Verification
A drifting fetch index shows up at the first grant after the fault as a wrong `rd_req_addr`. A wrong reading of the tail or of free space shows up as a burst length over the published or storable count. A queue pointer or count that has gone astray makes `desc_valid`, `desc_data` or `desc_index` disagree with the order of returned beats as soon as the next descriptor is offered. That is within one cycle of the faulty push or pop. A miscounted backlog of unwritten descriptors appears on `head_idx` in the cycle after the next completion strobe, and the clamp case is exercised on purpose to expose it.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  // Size of one descriptor in host memory and the matching address shift.
  localparam int DESC_BYTES = 16;
  localparam int DESC_SHIFT = $clog2(DESC_BYTES);
endpackage

// File: rtl/rxr_desc_fifo.sv
module rxr_desc_fifo #(
  parameter  int DESC_W = 128,
  parameter  int DEPTH  = 64,
  localparam int AW     = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DESC_W-1:0] push_data,
  input  logic              pop,
  output logic              empty,
  output logic [CNT_W-1:0]  count,
  output logic [DESC_W-1:0] front
);
  logic [DESC_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr, wr_nxt, rd_nxt;

  generate
    if ((1 << AW) == DEPTH) begin : g_pow2
      assign wr_nxt = wr_ptr + AW'(1);
      assign rd_nxt = rd_ptr + AW'(1);
    end else begin : g_mod
      assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
      assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= wr_nxt;
      if (pop)  rd_ptr <= rd_nxt;
      count <= count + (push ? CNT_W'(1) : '0) - (pop ? CNT_W'(1) : '0);
    end
  end

  assign empty = (count == '0);
  assign front = mem[rd_ptr];
endmodule

// File: rtl/rxr_fetch_ctrl.sv
module rxr_fetch_ctrl
  import rxr_pkg::*;
#(
  parameter  int ADDR_W    = 48,
  parameter  int IDX_W     = 16,
  parameter  int DEPTH     = 64,
  parameter  int BURST_MAX = 8,
  localparam int CNT_W     = $clog2(DEPTH + 1),
  localparam int LEN_W     = $clog2(BURST_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [IDX_W-1:0]  cfg_size,
  input  logic [IDX_W-1:0]  tail_idx,
  input  logic [CNT_W-1:0]  occ,
  input  logic              beat,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  output logic [LEN_W-1:0]  req_len,
  output logic [CNT_W-1:0]  outstanding
);
  localparam int CW = ((IDX_W > CNT_W) ? IDX_W : CNT_W) + 1;

  logic [IDX_W-1:0] fetch_idx;
  logic [CW-1:0]    avail, to_end, space, len_c, idx_sum;
  logic             load;

  // Burst length: smallest of the burst limit, published work,
  // distance to the ring end and free queue space.
  always_comb begin
    if (tail_idx >= fetch_idx) avail = CW'(tail_idx) - CW'(fetch_idx);
    else                       avail = CW'(tail_idx) + CW'(cfg_size) - CW'(fetch_idx);
    to_end = CW'(cfg_size) - CW'(fetch_idx);
    space  = CW'(DEPTH) - CW'(occ) - CW'(outstanding);
    len_c  = CW'(BURST_MAX);
    if (avail  < len_c) len_c = avail;
    if (to_end < len_c) len_c = to_end;
    if (space  < len_c) len_c = space;
  end

  assign load = !req_valid && (len_c != '0);

  always_comb begin
    idx_sum = CW'(fetch_idx) + len_c;
    if (idx_sum >= CW'(cfg_size)) idx_sum = idx_sum - CW'(cfg_size);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_valid   <= 1'b0;
      req_addr    <= '0;
      req_len     <= '0;
      fetch_idx   <= '0;
      outstanding <= '0;
    end else begin
      if (req_valid && req_ready) begin
        req_valid <= 1'b0;
      end else if (load) begin
        req_valid <= 1'b1;
        req_addr  <= cfg_base + (ADDR_W'(fetch_idx) << DESC_SHIFT);
        req_len   <= LEN_W'(len_c);
        fetch_idx <= IDX_W'(idx_sum);
      end
      outstanding <= outstanding + (load ? CNT_W'(len_c) : '0)
                                 - (beat ? CNT_W'(1) : '0);
    end
  end
endmodule

// File: rtl/rxr_head_track.sv
module rxr_head_track #(
  parameter int IDX_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] cfg_size,
  input  logic             pop,
  input  logic             wb_valid,
  input  logic [IDX_W-1:0] wb_count,
  output logic [IDX_W-1:0] cons_idx,
  output logic [IDX_W-1:0] head_idx,
  output logic [IDX_W-1:0] used
);
  logic [IDX_W-1:0] n_wb;

  function automatic logic [IDX_W-1:0] ring_adv(input logic [IDX_W-1:0] idx,
                                                input logic [IDX_W-1:0] n,
                                                input logic [IDX_W-1:0] sz);
    logic [IDX_W:0] s;
    s = {1'b0, idx} + {1'b0, n};
    if (s >= {1'b0, sz}) s = s - {1'b0, sz};
    return s[IDX_W-1:0];
  endfunction

  always_comb begin
    n_wb = '0;
    if (wb_valid) n_wb = (wb_count < used) ? wb_count : used;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cons_idx <= '0;
      head_idx <= '0;
      used     <= '0;
    end else begin
      if (pop) cons_idx <= ring_adv(cons_idx, IDX_W'(1), cfg_size);
      head_idx <= ring_adv(head_idx, n_wb, cfg_size);
      used     <= used - n_wb + (pop ? IDX_W'(1) : '0);
    end
  end
endmodule

// File: rtl/rx_desc_ring_fetcher.sv
module rx_desc_ring_fetcher #(
  parameter  int ADDR_W    = 48,
  parameter  int IDX_W     = 16,
  parameter  int DESC_W    = 128,
  parameter  int DEPTH     = 64,
  parameter  int BURST_MAX = 8,
  localparam int CNT_W     = $clog2(DEPTH + 1),
  localparam int LEN_W     = $clog2(BURST_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [IDX_W-1:0]  cfg_size,
  input  logic              tail_wr_en,
  input  logic [IDX_W-1:0]  tail_wr_idx,
  output logic [IDX_W-1:0]  head_idx,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ADDR_W-1:0] rd_req_addr,
  output logic [LEN_W-1:0]  rd_req_len,
  input  logic              rd_data_valid,
  input  logic [DESC_W-1:0] rd_data,
  output logic              desc_valid,
  input  logic              desc_ready,
  output logic [DESC_W-1:0] desc_data,
  output logic [IDX_W-1:0]  desc_index,
  output logic              no_desc,
  input  logic              wb_valid,
  input  logic [IDX_W-1:0]  wb_count
);
  logic [IDX_W-1:0] tail_idx_q;
  logic [CNT_W-1:0] fifo_count;
  logic [CNT_W-1:0] fetch_outst;
  logic [IDX_W-1:0] used_cnt;
  logic             fifo_empty;
  logic             take;
  logic             no_desc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tail_idx_q <= '0;
      no_desc_q  <= 1'b0;
    end else begin
      if (tail_wr_en) tail_idx_q <= tail_wr_idx;
      no_desc_q <= desc_ready & fifo_empty;
    end
  end

  assign take       = desc_ready & ~fifo_empty;
  assign desc_valid = ~fifo_empty;
  assign no_desc    = no_desc_q;

  rxr_fetch_ctrl #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .DEPTH(DEPTH), .BURST_MAX(BURST_MAX)
  ) u_fetch (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_base    (cfg_base),
    .cfg_size    (cfg_size),
    .tail_idx    (tail_idx_q),
    .occ         (fifo_count),
    .beat        (rd_data_valid),
    .req_valid   (rd_req_valid),
    .req_ready   (rd_req_ready),
    .req_addr    (rd_req_addr),
    .req_len     (rd_req_len),
    .outstanding (fetch_outst)
  );

  rxr_desc_fifo #(
    .DESC_W(DESC_W), .DEPTH(DEPTH)
  ) u_queue (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (rd_data_valid),
    .push_data (rd_data),
    .pop       (take),
    .empty     (fifo_empty),
    .count     (fifo_count),
    .front     (desc_data)
  );

  rxr_head_track #(
    .IDX_W(IDX_W)
  ) u_head (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_size (cfg_size),
    .pop      (take),
    .wb_valid (wb_valid),
    .wb_count (wb_count),
    .cons_idx (desc_index),
    .head_idx (head_idx),
    .used     (used_cnt)
  );
endmodule

// File: rtl/rxr_checker.sv
module rxr_checker
  import rxr_pkg::*;
#(
  parameter  int ADDR_W    = 48,
  parameter  int IDX_W     = 16,
  parameter  int DEPTH     = 64,
  parameter  int BURST_MAX = 8,
  localparam int CNT_W     = $clog2(DEPTH + 1),
  localparam int LEN_W     = $clog2(BURST_MAX + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] cfg_base,
  input logic [IDX_W-1:0]  cfg_size,
  input logic              rd_req_valid,
  input logic              rd_req_ready,
  input logic [ADDR_W-1:0] rd_req_addr,
  input logic [LEN_W-1:0]  rd_req_len,
  input logic              desc_valid,
  input logic              desc_ready,
  input logic [IDX_W-1:0]  desc_index,
  input logic              no_desc,
  input logic [IDX_W-1:0]  head_idx,
  input logic              wb_valid,
  input logic [CNT_W-1:0]  fifo_count,
  input logic [CNT_W-1:0]  fetch_outst
);
  logic [ADDR_W-1:0] req_off;
  logic [IDX_W+1:0]  req_end;
  logic [CNT_W:0]    committed;

  always_comb begin
    req_off   = rd_req_addr - cfg_base;
    req_end   = (IDX_W + 2)'(req_off >> DESC_SHIFT) + (IDX_W + 2)'(rd_req_len);
    committed = (CNT_W + 1)'(fifo_count) + (CNT_W + 1)'(fetch_outst);
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr) && $stable(rd_req_len)); // R6

  AST_BURST_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid |-> (rd_req_len != '0) && (rd_req_len <= LEN_W'(BURST_MAX))); // R4

  AST_NO_RING_END_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid |-> req_end <= (IDX_W + 2)'(cfg_size)); // R4

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    committed <= (CNT_W + 1)'(DEPTH)); // R5

  AST_EMPTY_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    desc_ready && !desc_valid |=> no_desc && $stable(desc_index)); // R8

  AST_HEAD_ON_WB_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !wb_valid |=> $stable(head_idx)); // R9

  AST_INDEX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (head_idx < cfg_size) && (desc_index < cfg_size)); // R10
endmodule

bind rx_desc_ring_fetcher rxr_checker #(
  .ADDR_W(ADDR_W), .IDX_W(IDX_W), .DEPTH(DEPTH), .BURST_MAX(BURST_MAX)
) u_rxr_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_base     (cfg_base),
  .cfg_size     (cfg_size),
  .rd_req_valid (rd_req_valid),
  .rd_req_ready (rd_req_ready),
  .rd_req_addr  (rd_req_addr),
  .rd_req_len   (rd_req_len),
  .desc_valid   (desc_valid),
  .desc_ready   (desc_ready),
  .desc_index   (desc_index),
  .no_desc      (no_desc),
  .head_idx     (head_idx),
  .wb_valid     (wb_valid),
  .fifo_count   (fifo_count),
  .fetch_outst  (fetch_outst)
);

// File: tb/rx_desc_ring_fetcher_tb_top.sv
module rx_desc_ring_fetcher_tb_top;
  localparam int ADDR_W = 48;
  localparam int IDX_W  = 16;
  localparam int DESC_W = 128;
  localparam int DEPTH  = 64;
  localparam int BURST  = 8;
  localparam int LEN_W  = $clog2(BURST + 1);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] cfg_base = '0;
  logic [IDX_W-1:0]  cfg_size = 16'd16;
  logic              tail_wr_en = 1'b0;
  logic [IDX_W-1:0]  tail_wr_idx = '0;
  logic [IDX_W-1:0]  head_idx;
  logic              rd_req_valid;
  logic              rd_req_ready = 1'b0;
  logic [ADDR_W-1:0] rd_req_addr;
  logic [LEN_W-1:0]  rd_req_len;
  logic              rd_data_valid = 1'b0;
  logic [DESC_W-1:0] rd_data = '0;
  logic              desc_valid;
  logic              desc_ready = 1'b0;
  logic [DESC_W-1:0] desc_data;
  logic [IDX_W-1:0]  desc_index;
  logic              no_desc;
  logic              wb_valid = 1'b0;
  logic [IDX_W-1:0]  wb_count = '0;

  always #5 clk = ~clk;

  rx_desc_ring_fetcher #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .DESC_W(DESC_W), .DEPTH(DEPTH), .BURST_MAX(BURST)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_size(cfg_size),
    .tail_wr_en(tail_wr_en), .tail_wr_idx(tail_wr_idx), .head_idx(head_idx),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
    .rd_req_addr(rd_req_addr), .rd_req_len(rd_req_len),
    .rd_data_valid(rd_data_valid), .rd_data(rd_data),
    .desc_valid(desc_valid), .desc_ready(desc_ready), .desc_data(desc_data),
    .desc_index(desc_index), .no_desc(no_desc),
    .wb_valid(wb_valid), .wb_count(wb_count)
  );

  // Reference model state
  int m_fidx, m_tail, m_head, m_cons, m_used, m_size;
  logic [DESC_W-1:0] mq[$];
  int  retq[$];
  int  g_idx[$];
  int  g_len[$];
  bit  m_nodesc;
  int  beats_granted, consumed, nodesc_cnt;
  bit  prev_pend;
  logic [ADDR_W-1:0] prev_addr;
  logic [LEN_W-1:0]  prev_len;

  // Stimulus controls, written by the main process
  bit grant_en = 1'b1;
  int grant_mask = 0, ret_mask = 0, cons_mask = 0;
  bit cons_en = 1'b0, auto_wb = 1'b0;
  int cons_left = 0, tail_req = -1, wb_req = -1;

  int cyc = 0, n_checks = 0, n_err = 0;

  function automatic logic [DESC_W-1:0] mk(input int i);
    return {32'hD5000000 | i, ~i, i * 3 + 7, 32'h5A5A0000 ^ i};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    int idx, pre, avail, n;
    bit pop;
    cyc++;
    if (!rst_n) begin
      m_fidx = 0; m_tail = 0; m_head = 0; m_cons = 0; m_used = 0;
      m_size = int'(cfg_size);
      mq.delete(); retq.delete(); g_idx.delete(); g_len.delete();
      m_nodesc = 0; beats_granted = 0; consumed = 0; nodesc_cnt = 0; prev_pend = 0;
      rd_req_ready = 0; rd_data_valid = 0; desc_ready = 0; wb_valid = 0; tail_wr_en = 0;
    end else begin
      // Compare outputs with the model state after the last edge
      chk(desc_valid == (mq.size() > 0), "R7", "desc_valid", longint'(desc_valid), longint'(mq.size() > 0));
      if (mq.size() > 0)
        chk(desc_data == mq[0], "R7", "desc_data", longint'(desc_data[63:0]), longint'(mq[0][63:0]));
      chk(int'(desc_index) == m_cons, "R10", "desc_index", longint'(desc_index), longint'(m_cons));
      chk(int'(head_idx) == m_head, "R9", "head_idx", longint'(head_idx), longint'(m_head));
      chk(no_desc == m_nodesc, "R8", "no_desc", longint'(no_desc), longint'(m_nodesc));
      if (no_desc) nodesc_cnt++;

      // Drive inputs for the coming edge
      rd_req_ready = grant_en && ((cyc & grant_mask) == 0);
      if (retq.size() > 0 && ((cyc & ret_mask) == 0)) begin
        idx = retq.pop_front();
        rd_data_valid = 1'b1;
        rd_data = mk(idx);
      end else begin
        rd_data_valid = 1'b0;
      end
      if (cons_left > 0) begin
        desc_ready = 1'b1;
        cons_left--;
      end else begin
        desc_ready = cons_en && ((cyc & cons_mask) == 0);
      end
      if (wb_req >= 0) begin
        wb_valid = 1'b1; wb_count = IDX_W'(wb_req); wb_req = -1;
      end else if (auto_wb && m_used >= 3) begin
        wb_valid = 1'b1; wb_count = IDX_W'(3);
      end else begin
        wb_valid = 1'b0;
      end
      if (tail_req >= 0) begin
        tail_wr_en = 1'b1; tail_wr_idx = IDX_W'(tail_req); tail_req = -1;
      end else begin
        tail_wr_en = 1'b0;
      end

      #1;
      // Model the coming edge from stable inputs and outputs
      if (rd_req_valid && rd_req_ready) begin
        avail = (m_tail - m_fidx + m_size) % m_size;
        chk(rd_req_addr == cfg_base + ADDR_W'(m_fidx) * 16, "R2", "rd_req_addr",
            longint'(rd_req_addr), longint'(cfg_base + ADDR_W'(m_fidx) * 16));
        chk(rd_req_len >= 1 && int'(rd_req_len) <= BURST, "R4", "rd_req_len range",
            longint'(rd_req_len), longint'(BURST));
        chk(m_fidx + int'(rd_req_len) <= m_size, "R4", "burst end",
            longint'(m_fidx + int'(rd_req_len)), longint'(m_size));
        chk(int'(rd_req_len) <= avail, "R3", "len vs tail", longint'(rd_req_len), longint'(avail));
        chk(mq.size() + retq.size() + int'(rd_data_valid) + int'(rd_req_len) <= DEPTH, "R5",
            "committed", longint'(mq.size() + retq.size() + int'(rd_req_len)), longint'(DEPTH));
        g_idx.push_back(m_fidx);
        g_len.push_back(int'(rd_req_len));
        for (int k = 0; k < int'(rd_req_len); k++) retq.push_back((m_fidx + k) % m_size);
        m_fidx = (m_fidx + int'(rd_req_len)) % m_size;
        beats_granted += int'(rd_req_len);
      end
      if (prev_pend)
        chk(rd_req_valid && rd_req_addr == prev_addr && rd_req_len == prev_len, "R6",
            "request hold", longint'(rd_req_addr), longint'(prev_addr));
      prev_pend = rd_req_valid && !rd_req_ready;
      prev_addr = rd_req_addr;
      prev_len  = rd_req_len;

      pre = mq.size();
      pop = 0;
      if (desc_ready && pre > 0) begin
        void'(mq.pop_front());
        m_cons = (m_cons + 1) % m_size;
        pop = 1;
        consumed++;
      end
      m_nodesc = desc_ready && (pre == 0);
      if (rd_data_valid) mq.push_back(rd_data);
      n = 0;
      if (wb_valid) n = (int'(wb_count) < m_used) ? int'(wb_count) : m_used;
      m_head = (m_head + n) % m_size;
      m_used = m_used - n + int'(pop);
      if (tail_wr_en) m_tail = int'(tail_wr_idx);
    end
  end

  task automatic start_phase(input int size, input logic [ADDR_W-1:0] base);
    @(negedge clk); #2;
    rst_n = 1'b0;
    cfg_size = IDX_W'(size);
    cfg_base = base;
    grant_en = 1; grant_mask = 0; ret_mask = 0; cons_en = 0; cons_mask = 0;
    auto_wb = 0; cons_left = 0; tail_req = -1; wb_req = -1;
    repeat (3) @(negedge clk);
    #2;
    chk(!rd_req_valid && !desc_valid && !no_desc, "R1", "outputs in reset",
        longint'({rd_req_valid, desc_valid, no_desc}), 0);
    chk(head_idx == '0 && desc_index == '0, "R1", "indices in reset",
        longint'({head_idx, desc_index}), 0);
    rst_n = 1'b1;
    @(negedge clk); #2;
    chk(!rd_req_valid && !desc_valid && head_idx == '0, "R1", "after reset",
        longint'({rd_req_valid, desc_valid}), 0);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_err++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    // Phase A: tail equals head, empty queue
    start_phase(16, 48'h1_0000);
    wait_cyc(20);
    chk(beats_granted == 0, "R3", "no fetch with tail at reset head", beats_granted, 0);
    tail_req = 0;
    wait_cyc(20);
    chk(beats_granted == 0, "R3", "no fetch after tail=head write", beats_granted, 0);
    cons_left = 1;
    wait_cyc(4);
    chk(nodesc_cnt == 1, "R8", "no_desc pulse count", nodesc_cnt, 1);
    chk(desc_index == '0, "R8", "index held on empty", longint'(desc_index), 0);

    // Phase B: wrap split and index wrap, size 10
    start_phase(10, 48'h2000_0000);
    tail_req = 7;
    wait_cyc(30);
    chk(g_len.size() == 1 && g_idx[0] == 0 && g_len[0] == 7, "R2", "first burst 0/7",
        longint'(g_len.size() > 0 ? g_len[0] : -1), 7);
    cons_en = 1;
    wait_cyc(20);
    cons_en = 0;
    chk(consumed == 7, "R7", "consumed all fetched", consumed, 7);
    chk(head_idx == '0, "R9", "head held before write-back", longint'(head_idx), 0);
    wb_req = 7;
    wait_cyc(4);
    chk(head_idx == 16'd7, "R9", "head after write-back", longint'(head_idx), 7);
    tail_req = 5;
    wait_cyc(30);
    chk(g_len.size() == 3, "R4", "wrap split burst count", g_len.size(), 3);
    if (g_len.size() == 3) begin
      chk(g_idx[1] == 7 && g_len[1] == 3, "R4", "burst up to ring end", g_len[1], 3);
      chk(g_idx[2] == 0 && g_len[2] == 5, "R4", "burst from index 0", g_len[2], 5);
    end
    cons_en = 1;
    wait_cyc(20);
    cons_en = 0;
    wb_req = 8;
    wait_cyc(4);
    chk(head_idx == 16'd5, "R10", "head wrapped", longint'(head_idx), 5);
    chk(desc_index == 16'd5, "R10", "desc index wrapped", longint'(desc_index), 5);

    // Phase C: queue full, slow grants, then resume
    start_phase(200, 48'h4000);
    grant_mask = 3;
    ret_mask = 1;
    tail_req = 150;
    wait_cyc(200);
    chk(beats_granted == 64, "R5", "fill stops at queue depth", beats_granted, 64);
    chk(!rd_req_valid, "R5", "no request when full", longint'(rd_req_valid), 0);
    cons_left = 10;
    wait_cyc(80);
    chk(beats_granted == 74, "R5", "fetch resumes by consumed count", beats_granted, 74);

    // Phase D: write-back count clamped to the unwritten backlog
    wb_req = 15;
    wait_cyc(4);
    chk(head_idx == 16'd10, "R9", "clamped head advance", longint'(head_idx), 10);

    // Phase E: long run with moving tail and varied pacing
    start_phase(37, 48'h8000_0000);
    auto_wb = 1;
    cons_en = 1;
    for (int p = 0; p < 6; p++) begin
      grant_mask = (p % 3 == 0) ? 0 : ((p % 3 == 1) ? 1 : 3);
      ret_mask   = (p % 2 == 0) ? 0 : 1;
      cons_mask  = (p < 3) ? 1 : 3;
      for (int s = 0; s < 25; s++) begin
        tail_req = (m_head + 36) % 37;
        wait_cyc(16);
      end
    end
    chk(consumed > 100, "R7", "descriptors flowed in long run", consumed, 100);

    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule